// File: doc/BRIEF.md
# CardBus Bridge Configuration Header Emulator

This block is a small register file that stands in for a CardBus bridge in configuration space. A configuration request names a bus, a device number, a dword index, a byte offset and a transfer size. When the request targets the bridge's fixed device number on the root bus, the block claims it. Reads return a header image in which the identity, class and header type are constants. Writes update the fields that are writable. Every request gets a registered response exactly one cycle later.

The block also keeps a sticky flag that shows that a card bus number has been assigned, and it drives the assigned number out. For each request it reports whether the request is a device-0 access on that card bus. Downstream logic uses this forward indication to re-issue the access as a type-0 cycle toward the card's select line.

Top module: `cbhdr_bridge`

## Requirements
- R1: After a synchronous reset, bus_assigned is 0, card_bus is 0, rsp_valid is 0, and every stored field reads as zero: the command dword reads 0x04000000, the interrupt dword reads 0x000001FF and the bus dword reads 0.
- R2: A request is claimed (rsp_claim=1) only when req_root=1 and req_dev=0x1E. The response (rsp_valid) appears exactly one cycle after req_valid. An unclaimed request returns rsp_rdata=0 and its write changes no state.
- R3: Dword 0 and dword 16 both read 0x634814E4 (device ID in the upper half, vendor ID in the lower half), and writes to them have no effect.
- R4: Dword 1 reads {0x0400, command}. A write stores only bits [15:0], so the status half stays 0x0400.
- R5: Dword 2 reads 0x06070000 (class code in [31:16]) and dword 3 reads 0x00020000 (header type in [23:16]). Both are read-only.
- R6: Dword 15 reads {bridge_control, 0x01, 0xFF}. A write stores bits [31:16] into bridge control with bits 8 and 9 (the prefetch enables) forced to 0. Bits [15:0] ignore writes.
- R7: Dword 6 packs latency [31:24], subordinate bus [23:16], card bus [15:8] and primary bus [7:0]. card_bus shows bits [15:8]. A write that leaves a nonzero card bus sets bus_assigned, which stays set until reset, even if card bus is later written to 0.
- R8: Dwords 7 to 14 are full 32-bit window registers (memory base 0, limit 0, base 1, limit 1, then I/O base 0, limit 0, base 1, limit 1). Dwords 11 and 13 read back with bit 0 forced to 1.
- R9: req_size 0 is a byte, 1 a halfword, and 2 or 3 a word. Sub-word reads return the dword shifted right by 8*req_off and zero-extended to the size. Word reads ignore req_off. Sub-word writes merge the low bytes of req_wdata, shifted left by 8*req_off and truncated at bit 31, into the current read image before the writable fields are stored.
- R10: Dwords outside 0, 1, 2, 3, 6, 7 to 14, 15 and 16 read as 0 and ignore writes.
- R11: rsp_fwd is 1 for a request that is not claimed, when bus_assigned is 1, req_bus equals card_bus and req_dev is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Configuration request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_root | input | 1 | Request targets the root bus |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_idx | input | 6 | Dword index within the header |
| req_off | input | 2 | Byte offset within the dword |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_claim | output | 1 | Request hit the emulated bridge |
| rsp_fwd | output | 1 | Request is to be forwarded to the card |
| rsp_rdata | output | 32 | Read data (0 for writes and misses) |
| bus_assigned | output | 1 | Sticky card-bus-assigned flag |
| card_bus | output | 8 | Stored card bus number |

## Verification
Each header dword is read at word size, and the identity dword is also read at byte and halfword sizes at several offsets, including a word read with a nonzero offset. This separates lane extraction from the plain read mux. Writes are applied as full words and as single bytes or halfwords aimed at read-only lanes (status, interrupt pin and line) and at writable ones. A halfword write at offset 3 checks that the shifted data is truncated and not wrapped. The card bus field is written to zero, then to nonzero, then back to zero, which shows the flag is sticky. Requests to a neighbouring device, to the right device on a non-root bus, and to card-bus device 0 and device 2 before and after assignment separate the claim decode from the forward decode.

// File: rtl/cbhdr_pkg.sv
package cbhdr_pkg;

  localparam int IDX_W     = 6;
  localparam int DATA_W    = 32;
  localparam int BUS_W     = 8;
  localparam int WIN_COUNT = 8;

  // Header dword indices (fixed by the configuration layout software expects)
  localparam logic [IDX_W-1:0] DW_ID        = 6'd0;
  localparam logic [IDX_W-1:0] DW_CMD       = 6'd1;
  localparam logic [IDX_W-1:0] DW_CLASS     = 6'd2;
  localparam logic [IDX_W-1:0] DW_HDR       = 6'd3;
  localparam logic [IDX_W-1:0] DW_BUS       = 6'd6;
  localparam logic [IDX_W-1:0] DW_WIN_FIRST = 6'd7;
  localparam logic [IDX_W-1:0] DW_WIN_LAST  = 6'd14;
  localparam logic [IDX_W-1:0] DW_IRQ       = 6'd15;
  localparam logic [IDX_W-1:0] DW_SUBID     = 6'd16;

  localparam logic [15:0] STATUS_FIXED = 16'h0400;
  localparam logic [15:0] CLASS_FIXED  = 16'h0607;
  localparam logic [7:0]  HDR_TYPE     = 8'h02;
  localparam logic [7:0]  IRQ_PIN      = 8'h01;
  localparam logic [7:0]  IRQ_LINE     = 8'hFF;
  localparam logic [15:0] PF_STRIP     = 16'h0300;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } xfer_size_e;

  typedef struct packed {
    logic [15:0]      cmd;
    logic [15:0]      brctl;
    logic [BUS_W-1:0] lat;
    logic [BUS_W-1:0] sub_bus;
    logic [BUS_W-1:0] card_bus;
    logic [BUS_W-1:0] prim_bus;
  } hdr_state_t;

endpackage

// File: rtl/cbhdr_lane.sv
module cbhdr_lane
  import cbhdr_pkg::*;
(
  input  logic [1:0]        off,
  input  xfer_size_e        size,
  input  logic [DATA_W-1:0] cur,
  input  logic [DATA_W-1:0] wval,
  output logic [DATA_W-1:0] rd,
  output logic [DATA_W-1:0] merged
);
  localparam int BYTES = DATA_W / 8;

  logic [4:0]        sh;
  logic [DATA_W-1:0] cur_down;
  logic [DATA_W-1:0] lane_mask;
  logic [DATA_W-1:0] wshift;

  assign sh       = {off, 3'b000};
  assign cur_down = cur >> sh;

  always_comb begin
    case (size)
      SZ_BYTE: begin
        lane_mask = 32'h0000_00FF << sh;
        wshift    = {24'b0, wval[7:0]} << sh;
        rd        = cur_down & 32'h0000_00FF;
      end
      SZ_HALF: begin
        lane_mask = 32'h0000_FFFF << sh;
        wshift    = {16'b0, wval[15:0]} << sh;
        rd        = cur_down & 32'h0000_FFFF;
      end
      default: begin
        lane_mask = '1;
        wshift    = wval;
        rd        = cur;
      end
    endcase
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign merged[8*b +: 8] = lane_mask[8*b] ? wshift[8*b +: 8] : cur[8*b +: 8];
  end

endmodule

// File: rtl/cbhdr_view.sv
module cbhdr_view
  import cbhdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h14E4,
  parameter logic [15:0] DEVICE_ID = 16'h6348
) (
  input  logic [IDX_W-1:0]                  idx,
  input  hdr_state_t                        st,
  input  logic [WIN_COUNT-1:0][DATA_W-1:0]  win,
  output logic [DATA_W-1:0]                 word
);
  localparam int WSEL_W = $clog2(WIN_COUNT);

  logic [WSEL_W-1:0] wsel;
  logic              in_win;
  logic              io_base;

  assign wsel    = WSEL_W'(idx - DW_WIN_FIRST);
  assign in_win  = (idx >= DW_WIN_FIRST) && (idx <= DW_WIN_LAST);
  // Window slots 4 and 6 are the two I/O bases
  assign io_base = wsel[WSEL_W-1] && !wsel[0];

  always_comb begin
    word = '0;
    case (idx)
      DW_ID, DW_SUBID: word = {DEVICE_ID, VENDOR_ID};
      DW_CMD:          word = {STATUS_FIXED, st.cmd};
      DW_CLASS:        word = {CLASS_FIXED, 16'h0000};
      DW_HDR:          word = {8'h00, HDR_TYPE, 16'h0000};
      DW_BUS:          word = {st.lat, st.sub_bus, st.card_bus, st.prim_bus};
      DW_IRQ:          word = {st.brctl, IRQ_PIN, IRQ_LINE};
      default: begin
        if (in_win) begin
          word = win[wsel];
          if (io_base) word[0] = 1'b1;
        end
      end
    endcase
  end

endmodule

// File: rtl/cbhdr_regs.sv
module cbhdr_regs
  import cbhdr_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [IDX_W-1:0]                  idx,
  input  logic [DATA_W-1:0]                 data,
  output hdr_state_t                        st,
  output logic [WIN_COUNT-1:0][DATA_W-1:0]  win,
  output logic                              assigned
);
  logic [DATA_W-1:0] win_q [WIN_COUNT];

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= '0;
      assigned <= 1'b0;
    end else if (wr_en) begin
      case (idx)
        DW_CMD: st.cmd <= data[15:0];
        DW_BUS: begin
          {st.lat, st.sub_bus, st.card_bus, st.prim_bus} <= data;
          if (data[15:8] != '0) assigned <= 1'b1;
        end
        DW_IRQ: st.brctl <= data[31:16] & ~PF_STRIP;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    for (int w = 0; w < WIN_COUNT; w++) begin
      if (rst) win_q[w] <= '0;
      else if (wr_en && idx == DW_WIN_FIRST + IDX_W'(w)) win_q[w] <= data;
    end
  end

  for (genvar w = 0; w < WIN_COUNT; w++) begin : g_win_out
    assign win[w] = win_q[w];
  end

  AST_ASSIGNED_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(assigned) |-> assigned); // R7

  AST_ASSIGN_ON_CARDBUS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == DW_BUS && data[15:8] != 8'h00) |=> assigned); // R7

  AST_PREFETCH_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == DW_IRQ) |=> (st.brctl[9:8] == 2'b00)); // R6

endmodule

// File: rtl/cbhdr_bridge.sv
module cbhdr_bridge
  import cbhdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'h14E4,
  parameter logic [15:0] DEVICE_ID  = 16'h6348,
  parameter int          DEV_W      = 5,
  parameter logic [4:0]  BRIDGE_DEV = 5'h1E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_root,
  input  logic [7:0]        req_bus,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [5:0]        req_idx,
  input  logic [1:0]        req_off,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_claim,
  output logic              rsp_fwd,
  output logic [31:0]       rsp_rdata,
  output logic              bus_assigned,
  output logic [7:0]        card_bus
);
  hdr_state_t                       st;
  logic [WIN_COUNT-1:0][DATA_W-1:0] win;
  logic                             assigned;
  logic [DATA_W-1:0]                view_word;
  logic [DATA_W-1:0]                lane_rd;
  logic [DATA_W-1:0]                lane_merged;
  logic                             slot_hit;
  logic                             fwd_hit;

  assign slot_hit = req_valid && req_root && (req_dev == DEV_W'(BRIDGE_DEV));
  assign fwd_hit  = req_valid && !slot_hit && assigned &&
                    (req_bus == st.card_bus) && (req_dev == '0);

  cbhdr_view #(.VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID)) u_view (
    .idx  (req_idx),
    .st   (st),
    .win  (win),
    .word (view_word)
  );

  cbhdr_lane u_lane (
    .off    (req_off),
    .size   (xfer_size_e'(req_size)),
    .cur    (view_word),
    .wval   (req_wdata),
    .rd     (lane_rd),
    .merged (lane_merged)
  );

  cbhdr_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (slot_hit && req_write),
    .idx      (req_idx),
    .data     (lane_merged),
    .st       (st),
    .win      (win),
    .assigned (assigned)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_claim <= 1'b0;
      rsp_fwd   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_claim <= slot_hit;
      rsp_fwd   <= fwd_hit;
      rsp_rdata <= (slot_hit && !req_write) ? lane_rd : '0;
    end
  end

  assign bus_assigned = assigned;
  assign card_bus     = st.card_bus;

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R2

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R2

  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_claim) |-> (rsp_rdata == '0)); // R2

  AST_CLAIM_FWD_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rsp_claim && rsp_fwd)); // R11

  AST_FWD_NEEDS_ASSIGN: assert property (@(posedge clk) disable iff (rst)
    rsp_fwd |-> bus_assigned); // R11

endmodule

// File: tb/sim_cbhdr_bridge.sv
`timescale 1ns/1ps
module sim_cbhdr_bridge;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic        req_root = 1'b0;
  logic [7:0]  req_bus = '0;
  logic [4:0]  req_dev = '0;
  logic [5:0]  req_idx = '0;
  logic [1:0]  req_off = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_claim, rsp_fwd, bus_assigned;
  logic [31:0] rsp_rdata;
  logic [7:0]  card_bus;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic        claim;
    logic        fwd;
    logic [31:0] data;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  cbhdr_bridge u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_root(req_root), .req_bus(req_bus), .req_dev(req_dev),
    .req_idx(req_idx), .req_off(req_off), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_claim(rsp_claim),
    .rsp_fwd(rsp_fwd), .rsp_rdata(rsp_rdata), .bus_assigned(bus_assigned),
    .card_bus(card_bus)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Driver: one request, expectation pushed to the scoreboard
  task automatic issue(input logic root, input logic [7:0] bus, input logic [4:0] dev,
                       input logic wr, input logic [5:0] idx, input logic [1:0] off,
                       input logic [1:0] size, input logic [31:0] wd,
                       input logic eclaim, input logic efwd, input logic [31:0] edata,
                       input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_root = root; req_bus = bus;
    req_dev = dev; req_idx = idx; req_off = off; req_size = size; req_wdata = wd;
    e.claim = eclaim; e.fwd = efwd; e.data = edata; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic brd(input logic [5:0] idx, input logic [1:0] off, input logic [1:0] size,
                     input logic [31:0] edata, input string tag);
    issue(1'b1, 8'h00, 5'h1E, 1'b0, idx, off, size, 32'h0, 1'b1, 1'b0, edata, tag);
  endtask

  task automatic bwr(input logic [5:0] idx, input logic [1:0] off, input logic [1:0] size,
                     input logic [31:0] wd, input string tag);
    issue(1'b1, 8'h00, 5'h1E, 1'b1, idx, off, size, wd, 1'b1, 1'b0, 32'h0, tag);
  endtask

  task automatic chk_state(input logic ea, input logic [7:0] ecb, input string tag);
    check({tag, " bus_assigned"}, {31'b0, bus_assigned}, {31'b0, ea});
    check({tag, " card_bus"}, {24'b0, card_bus}, {24'b0, ecb});
  endtask

  // Monitor: pops and compares each response
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rsp_valid === 1'b1) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2 unexpected response actual=1 expected=0");
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check({e.tag, " claim"}, {31'b0, rsp_claim}, {31'b0, e.claim});
          check({e.tag, " fwd"}, {31'b0, rsp_fwd}, {31'b0, e.fwd});
          check({e.tag, " data"}, rsp_rdata, e.data);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 rsp_valid in reset", {31'b0, rsp_valid}, 32'h0);
    chk_state(1'b0, 8'h00, "R1 reset");
    rst = 1'b0;
    brd(6'd1, 2'd0, 2'd2, 32'h0400_0000, "R1 R4 command after reset");
    brd(6'd15, 2'd0, 2'd2, 32'h0000_01FF, "R1 R6 irq after reset");
    brd(6'd6, 2'd0, 2'd2, 32'h0000_0000, "R1 R7 bus after reset");
    // R11 no forward before assignment
    issue(1'b0, 8'h00, 5'h00, 1'b0, 6'd0, 2'd0, 2'd2, 32'h0, 1'b0, 1'b0, 32'h0, "R11 unassigned no fwd");

    // R3 identity
    brd(6'd0, 2'd0, 2'd2, 32'h6348_14E4, "R3 id dword");
    brd(6'd16, 2'd0, 2'd2, 32'h6348_14E4, "R3 subsystem dword");
    bwr(6'd0, 2'd0, 2'd2, 32'h0, "R3 write id");
    brd(6'd0, 2'd0, 2'd2, 32'h6348_14E4, "R3 id after write");
    // R9 read lanes
    brd(6'd0, 2'd2, 2'd0, 32'h0000_0048, "R9 byte off2");
    brd(6'd0, 2'd2, 2'd1, 32'h0000_6348, "R9 half off2");
    brd(6'd0, 2'd0, 2'd0, 32'h0000_00E4, "R9 byte off0");
    brd(6'd0, 2'd3, 2'd3, 32'h6348_14E4, "R9 word ignores offset");

    // R4 command
    bwr(6'd1, 2'd0, 2'd2, 32'hFFFF_0146, "R4 write command");
    brd(6'd1, 2'd0, 2'd2, 32'h0400_0146, "R4 command readback");
    bwr(6'd1, 2'd1, 2'd0, 32'h0000_0005, "R9 byte merge command");
    brd(6'd1, 2'd0, 2'd2, 32'h0400_0546, "R9 command merged");
    bwr(6'd1, 2'd2, 2'd0, 32'h0000_0077, "R4 write status byte");
    brd(6'd1, 2'd0, 2'd2, 32'h0400_0546, "R4 status unchanged");

    // R5 class and header type
    brd(6'd2, 2'd0, 2'd2, 32'h0607_0000, "R5 class");
    brd(6'd3, 2'd0, 2'd2, 32'h0002_0000, "R5 header type");
    bwr(6'd2, 2'd0, 2'd2, 32'hFFFF_FFFF, "R5 write class");
    brd(6'd2, 2'd0, 2'd2, 32'h0607_0000, "R5 class after write");

    // R6 bridge control
    bwr(6'd15, 2'd2, 2'd1, 32'h0000_FFFF, "R6 write brctl half");
    brd(6'd15, 2'd0, 2'd2, 32'hFCFF_01FF, "R6 prefetch stripped");
    bwr(6'd15, 2'd0, 2'd0, 32'h0000_0033, "R6 write irq line");
    brd(6'd15, 2'd0, 2'd2, 32'hFCFF_01FF, "R6 line unchanged");
    bwr(6'd15, 2'd3, 2'd0, 32'h0000_0003, "R6 write brctl high byte");
    brd(6'd15, 2'd0, 2'd2, 32'h00FF_01FF, "R6 high byte stripped");

    // R7 bus numbers and sticky flag
    bwr(6'd6, 2'd0, 2'd0, 32'h0000_0001, "R7 write primary");
    chk_state(1'b0, 8'h00, "R7 primary only");
    bwr(6'd6, 2'd1, 2'd0, 32'h0000_0005, "R7 write card bus");
    chk_state(1'b1, 8'h05, "R7 card bus set");
    brd(6'd6, 2'd0, 2'd2, 32'h0000_0501, "R7 bus dword");
    bwr(6'd6, 2'd0, 2'd2, 32'h400A_0001, "R7 write card bus zero");
    chk_state(1'b1, 8'h00, "R7 sticky flag");
    brd(6'd6, 2'd0, 2'd2, 32'h400A_0001, "R7 bus dword packed");
    bwr(6'd6, 2'd1, 2'd0, 32'h0000_0005, "R7 restore card bus");
    brd(6'd6, 2'd0, 2'd2, 32'h400A_0501, "R7 bus dword restored");

    // R8 windows
    bwr(6'd11, 2'd0, 2'd2, 32'h0000_1000, "R8 io base0 write");
    brd(6'd11, 2'd0, 2'd2, 32'h0000_1001, "R8 io base0 bit0");
    bwr(6'd12, 2'd0, 2'd2, 32'h0000_1FF0, "R8 io limit0 write");
    brd(6'd12, 2'd0, 2'd2, 32'h0000_1FF0, "R8 io limit0");
    bwr(6'd13, 2'd0, 2'd2, 32'h0000_0000, "R8 io base1 write");
    brd(6'd13, 2'd0, 2'd2, 32'h0000_0001, "R8 io base1 bit0");
    bwr(6'd7, 2'd0, 2'd2, 32'h1234_5678, "R8 mem base0 write");
    brd(6'd7, 2'd0, 2'd2, 32'h1234_5678, "R8 mem base0");
    bwr(6'd14, 2'd0, 2'd2, 32'hFFFF_FFFE, "R8 io limit1 write");
    brd(6'd14, 2'd0, 2'd2, 32'hFFFF_FFFE, "R8 io limit1");
    // R9 window lanes
    bwr(6'd9, 2'd2, 2'd1, 32'h0000_A000, "R9 half write off2");
    brd(6'd9, 2'd0, 2'd2, 32'hA000_0000, "R9 half merged");
    brd(6'd7, 2'd1, 2'd0, 32'h0000_0056, "R9 byte read off1");
    bwr(6'd10, 2'd3, 2'd1, 32'h0000_BEEF, "R9 half write off3");
    brd(6'd10, 2'd0, 2'd2, 32'hEF00_0000, "R9 off3 truncated");
    brd(6'd10, 2'd3, 2'd1, 32'h0000_00EF, "R9 half read off3");

    // R10 unlisted dwords
    bwr(6'd5, 2'd0, 2'd2, 32'hFFFF_FFFF, "R10 write unlisted");
    brd(6'd5, 2'd0, 2'd2, 32'h0, "R10 unlisted dw5");
    brd(6'd4, 2'd0, 2'd2, 32'h0, "R10 unlisted dw4");
    brd(6'd17, 2'd0, 2'd2, 32'h0, "R10 unlisted dw17");
    brd(6'd63, 2'd0, 2'd2, 32'h0, "R10 unlisted dw63");

    // R2 claim decode
    issue(1'b1, 8'h00, 5'h1D, 1'b0, 6'd0, 2'd0, 2'd2, 32'h0, 1'b0, 1'b0, 32'h0, "R2 wrong device");
    issue(1'b0, 8'h03, 5'h1E, 1'b0, 6'd0, 2'd0, 2'd2, 32'h0, 1'b0, 1'b0, 32'h0, "R2 non-root bus");
    issue(1'b1, 8'h00, 5'h1D, 1'b1, 6'd1, 2'd0, 2'd2, 32'h0, 1'b0, 1'b0, 32'h0, "R2 miss write");
    brd(6'd1, 2'd0, 2'd2, 32'h0400_0546, "R2 command untouched by miss");

    // R11 forward decode
    issue(1'b0, 8'h05, 5'h00, 1'b0, 6'd0, 2'd0, 2'd2, 32'h0, 1'b0, 1'b1, 32'h0, "R11 forward hit");
    issue(1'b0, 8'h05, 5'h02, 1'b0, 6'd0, 2'd0, 2'd2, 32'h0, 1'b0, 1'b0, 32'h0, "R11 wrong device");
    issue(1'b0, 8'h06, 5'h00, 1'b0, 6'd0, 2'd0, 2'd2, 32'h0, 1'b0, 1'b0, 32'h0, "R11 wrong bus");

    // R1 R7 reset clears sticky flag
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk_state(1'b0, 8'h00, "R1 R7 second reset");
    rst = 1'b0;
    brd(6'd11, 2'd0, 2'd2, 32'h0000_0001, "R1 window cleared");
    brd(6'd1, 2'd0, 2'd2, 32'h0400_0000, "R1 command cleared");

    repeat (3) @(negedge clk);
    check("R2 scoreboard drained", exp_q.size(), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule